// File: doc/BRIEF.md
# FIFO Flag Offset Programming Controller

This block sets the two threshold offsets that a FIFO's programmable flags compare against: the almost-empty offset (X) and the almost-full offset (Y). It runs on the write-side clock and picks one of three ways of loading the offsets. Two dual-purpose pins choose the method. While reset is held they act as a mode code. The code present in the last reset cycle is kept. After reset the same two pins become an active-low serial enable and a serial data bit.

The methods are: a fixed preset (a small or a large value written into both offsets), parallel capture of two words from the write data bus, and a serial stream of 2×log2(DEPTH) bits. The serial stream carries Y first and X second, each most significant bit first. When loading finishes the block raises a done flag and freezes both offsets until the next reset. Write strobes are not passed on to the FIFO until then. The flag comparators and the FIFO storage sit outside this block.

Top module: `offset_prog_ctrl`

## Requirements
- R1: While rst_n is low, x_ofs and y_ofs read 0, prog_done reads 0 and fifo_wr_en stays 0 even when wr_en is 1.
- R2: The method is set by {cfg_sel_n, cfg_dat} in the last clock cycle with rst_n low: 2'b00 preset low, 2'b01 preset high, 2'b10 parallel, 2'b11 serial. Changing these pins after reset does not change the method.
- R3: Preset low mode loads PRESET_LO (default 8) into both X and Y. prog_done reads 1 after the first rising clock with rst_n high.
- R4: Preset high mode loads PRESET_HI (default 64) into both X and Y, with the same timing as R3.
- R5: In parallel mode the first clock with wr_en high after reset loads wr_data[AW-1:0] into Y. The second loads wr_data[AW-1:0] into X and sets prog_done. The upper data bits are ignored.
- R6: fifo_wr_en is 0 until prog_done is 1, and that includes the two configuration words of parallel mode. From then on fifo_wr_en follows wr_en.
- R7: In serial mode each rising clock with cfg_sel_n low shifts cfg_dat into the offsets. The first bit becomes the MSB of Y and the last bit becomes the LSB of X. Clocks with cfg_sel_n high shift nothing.
- R8: prog_done is set after exactly 2×AW serial bits (20 for DEPTH 1024). Any serial bits after that leave X and Y unchanged.
- R9: Once prog_done is 1 it stays 1, and X and Y keep their values until the next reset, whatever the write or serial pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| rst_n | input | 1 | Active-low synchronous reset; the method is captured from the cycles it is low |
| cfg_sel_n | input | 1 | Mode bit 1 during reset; active-low serial enable afterwards |
| cfg_dat | input | 1 | Mode bit 0 during reset; serial data bit afterwards |
| wr_en | input | 1 | Write strobe from the write-side port |
| wr_data | input | DATA_W | Write data bus |
| x_ofs | output | AW | Almost-empty offset |
| y_ofs | output | AW | Almost-full offset |
| prog_done | output | 1 | Offsets are loaded and frozen |
| fifo_wr_en | output | 1 | Write strobe forwarded to the FIFO once loading is done |

## Verification
The assertions assume that the mode pins are held steady through the final reset cycle. They also assume that reset lasts long enough to clear every loader. In serial mode the pins are treated as a clean enable/data pair from the first clock after reset.

The bench drives all inputs on the falling clock edge, so each value is steady across the rising edge that samples it. It keeps the mode code on the pins at the edge where reset is released, and changes them only afterwards. Serial streams include idle gaps with the enable high and the data bit toggling. Extra bits are sent after completion to show they have no effect.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
   typedef enum logic [1:0] {
      M_PRESET_LO = 2'b00,
      M_PRESET_HI = 2'b01,
      M_PARALLEL  = 2'b10,
      M_SERIAL    = 2'b11
   } ofs_mode_e;
endpackage

// File: rtl/ofs_mode_latch.sv
// Tracks the mode pins during reset; the value of the final reset cycle is kept.
module ofs_mode_latch
   import ofs_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin_hi,
   input  logic      pin_lo,
   output ofs_mode_e mode
);
   always_ff @(posedge clk) begin
      if (!rst_n) mode <= ofs_mode_e'({pin_hi, pin_lo});
   end
endmodule

// File: rtl/ofs_preset_unit.sv
// Loads one of two constant offsets on the first clock after reset.
module ofs_preset_unit #(
   parameter int AW = 10,
   parameter int LO = 8,
   parameter int HI = 64
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          pick_hi,
   output logic [AW-1:0] val,
   output logic          done
);
   localparam logic [AW-1:0] LO_V = AW'(LO);
   localparam logic [AW-1:0] HI_V = AW'(HI);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val  <= '0;
         done <= 1'b0;
      end else if (active && !done) begin
         val  <= pick_hi ? HI_V : LO_V;
         done <= 1'b1;
      end
   end
endmodule

// File: rtl/ofs_parallel_loader.sv
// Captures Y from the first write word and X from the second.
module ofs_parallel_loader #(
   parameter int AW     = 10,
   parameter int DATA_W = 36
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [AW-1:0]     y_val,
   output logic [AW-1:0]     x_val,
   output logic              done
);
   logic have_y;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_val  <= '0;
         x_val  <= '0;
         have_y <= 1'b0;
         done   <= 1'b0;
      end else if (active && wr_en && !done) begin
         if (!have_y) begin
            y_val  <= wr_data[AW-1:0];
            have_y <= 1'b1;
         end else begin
            x_val <= wr_data[AW-1:0];
            done  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/ofs_serial_loader.sv
// Shifts a combined Y-then-X stream, MSB first, under an active-low enable.
module ofs_serial_loader #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          active,
   input  logic          sen_n,
   input  logic          sdat,
   output logic [AW-1:0] y_val,
   output logic [AW-1:0] x_val,
   output logic          done
);
   localparam int NBITS = 2 * AW;
   localparam int CW    = $clog2(NBITS + 1);
   localparam logic [CW-1:0] LAST = CW'(NBITS - 1);

   logic [NBITS-1:0] shreg;
   logic [CW-1:0]    cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
         done  <= 1'b0;
      end else if (active && !sen_n && !done) begin
         shreg <= {shreg[NBITS-2:0], sdat};
         cnt   <= cnt + 1'b1;
         if (cnt == LAST) done <= 1'b1;
      end
   end

   assign y_val = shreg[NBITS-1:AW];
   assign x_val = shreg[AW-1:0];
endmodule

// File: rtl/offset_prog_ctrl.sv
module offset_prog_ctrl
   import ofs_pkg::*;
#(
   parameter int DEPTH     = 1024,
   parameter int DATA_W    = 36,
   parameter int PRESET_LO = 8,
   parameter int PRESET_HI = 64,
   localparam int AW       = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_sel_n,
   input  logic              cfg_dat,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [AW-1:0]     x_ofs,
   output logic [AW-1:0]     y_ofs,
   output logic              prog_done,
   output logic              fifo_wr_en
);
   initial begin
      assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("DEPTH must be a power of two of at least 4");
      assert (DATA_W >= AW) else $error("DATA_W narrower than offset width");
      assert (PRESET_LO < DEPTH && PRESET_HI < DEPTH)
         else $error("preset offsets must fit below DEPTH");
   end

   ofs_mode_e mode_q;

   logic [AW-1:0] pre_val;
   logic          pre_done;
   logic [AW-1:0] par_y, par_x;
   logic          par_done;
   logic [AW-1:0] ser_y, ser_x;
   logic          ser_done;

   ofs_mode_latch u_mode (
      .clk(clk), .rst_n(rst_n), .pin_hi(cfg_sel_n), .pin_lo(cfg_dat), .mode(mode_q)
   );

   ofs_preset_unit #(.AW(AW), .LO(PRESET_LO), .HI(PRESET_HI)) u_pre (
      .clk(clk), .rst_n(rst_n),
      .active(mode_q == M_PRESET_LO || mode_q == M_PRESET_HI),
      .pick_hi(mode_q == M_PRESET_HI),
      .val(pre_val), .done(pre_done)
   );

   ofs_parallel_loader #(.AW(AW), .DATA_W(DATA_W)) u_par (
      .clk(clk), .rst_n(rst_n), .active(mode_q == M_PARALLEL),
      .wr_en(wr_en), .wr_data(wr_data),
      .y_val(par_y), .x_val(par_x), .done(par_done)
   );

   ofs_serial_loader #(.AW(AW)) u_ser (
      .clk(clk), .rst_n(rst_n), .active(mode_q == M_SERIAL),
      .sen_n(cfg_sel_n), .sdat(cfg_dat),
      .y_val(ser_y), .x_val(ser_x), .done(ser_done)
   );

   always_comb begin
      case (mode_q)
         M_PARALLEL: begin
            x_ofs = par_x; y_ofs = par_y; prog_done = par_done;
         end
         M_SERIAL: begin
            x_ofs = ser_x; y_ofs = ser_y; prog_done = ser_done;
         end
         default: begin
            x_ofs = pre_val; y_ofs = pre_val; prog_done = pre_done;
         end
      endcase
   end

   assign fifo_wr_en = wr_en & prog_done;
endmodule

// File: rtl/ofs_prog_checker.sv
module ofs_prog_checker #(
   parameter int AW = 10,
   parameter int LO = 8,
   parameter int HI = 64
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_sel_n,
   input logic          wr_en,
   input logic [AW-1:0] x_ofs,
   input logic [AW-1:0] y_ofs,
   input logic          prog_done,
   input logic          fifo_wr_en,
   input logic [1:0]    mode
);
   localparam int NB = 2 * AW;
   localparam int CW = $clog2(NB + 2);

   logic [CW-1:0] bit_cnt;
   logic [1:0]    word_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bit_cnt  <= '0;
         word_cnt <= '0;
      end else if (!prog_done) begin
         if (mode == 2'b11 && !cfg_sel_n) bit_cnt <= bit_cnt + 1'b1;
         if (mode == 2'b10 && wr_en && word_cnt != 2'd3) word_cnt <= word_cnt + 1'b1;
      end
   end

   assert_mode_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(mode));

   assert_preset_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(prog_done) && mode == 2'b00) |-> (x_ofs == AW'(LO) && y_ofs == AW'(LO)));

   assert_preset_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(prog_done) && mode == 2'b01) |-> (x_ofs == AW'(HI) && y_ofs == AW'(HI)));

   assert_two_words_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(prog_done) && mode == 2'b10) |-> word_cnt == 2'd2);

   assert_no_early_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_wr_en |-> $past(prog_done) || prog_done);

   assert_bit_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(prog_done) && mode == 2'b11) |-> bit_cnt == CW'(NB));

   assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      prog_done |=> (prog_done && $stable(x_ofs) && $stable(y_ofs)));
endmodule

bind offset_prog_ctrl ofs_prog_checker #(.AW(AW), .LO(PRESET_LO), .HI(PRESET_HI)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_sel_n(cfg_sel_n), .wr_en(wr_en),
   .x_ofs(x_ofs), .y_ofs(y_ofs), .prog_done(prog_done),
   .fifo_wr_en(fifo_wr_en), .mode(mode_q)
);

// File: tb/offset_prog_ctrl_bench.sv
`timescale 1ns/1ps
module offset_prog_ctrl_bench;
   localparam int DEPTH = 1024;
   localparam int DW    = 36;
   localparam int AW    = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_sel_n = 1'b1;
   logic          cfg_dat = 1'b1;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [AW-1:0] x_ofs, y_ofs;
   logic          prog_done, fifo_wr_en;

   int errs = 0;
   int checks = 0;

   always #4 clk = ~clk;

   offset_prog_ctrl #(.DEPTH(DEPTH), .DATA_W(DW)) u_offset_prog_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_sel_n(cfg_sel_n), .cfg_dat(cfg_dat),
      .wr_en(wr_en), .wr_data(wr_data), .x_ofs(x_ofs), .y_ofs(y_ofs),
      .prog_done(prog_done), .fifo_wr_en(fifo_wr_en)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] code);
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0;
      {cfg_sel_n, cfg_dat} = code;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b1; {cfg_sel_n, cfg_dat} = 2'b00;
      repeat (3) @(negedge clk);
      check("R1 x", 32'(x_ofs), 0);
      check("R1 y", 32'(y_ofs), 0);
      check("R1 done", 32'(prog_done), 0);
      check("R1 fifo_wr_en", 32'(fifo_wr_en), 0);
      wr_en = 1'b0;
   endtask

   task automatic t_preset(input logic hi);
      logic [AW-1:0] exp;
      exp = hi ? AW'(64) : AW'(8);
      do_reset({1'b0, hi});
      check("R3 done before first edge", 32'(prog_done), 0);
      {cfg_sel_n, cfg_dat} = 2'b11;   // R2: pin change after release ignored
      @(negedge clk);
      check(hi ? "R4 done" : "R3 done", 32'(prog_done), 1);
      check(hi ? "R4 x" : "R3 x", 32'(x_ofs), 32'(exp));
      check(hi ? "R4 y" : "R3 y", 32'(y_ofs), 32'(exp));
      cfg_sel_n = 1'b0;
      repeat (4) @(negedge clk);
      check("R2 pins after reset no effect", 32'({x_ofs, y_ofs}), 32'({exp, exp}));
      cfg_sel_n = 1'b1;
   endtask

   task automatic t_parallel;
      do_reset(2'b10);
      wr_en = 1'b1; wr_data = {26'h2ABCDEF, 10'h2A5};
      #1 check("R6 first cfg word blocked", 32'(fifo_wr_en), 0);
      @(negedge clk);
      check("R5 y after word 1", 32'(y_ofs), 32'h2A5);
      check("R5 not done after word 1", 32'(prog_done), 0);
      wr_data = {26'h1555555, 10'h0C3};
      #1 check("R6 second cfg word blocked", 32'(fifo_wr_en), 0);
      @(negedge clk);
      wr_en = 1'b0;
      check("R5 done", 32'(prog_done), 1);
      check("R5 x", 32'(x_ofs), 32'h0C3);
      check("R5 y", 32'(y_ofs), 32'h2A5);
      #1 check("R6 idle", 32'(fifo_wr_en), 0);
      @(negedge clk);
      wr_en = 1'b1; wr_data = 36'h0_0000_0111;
      #1 check("R6 write passes", 32'(fifo_wr_en), 1);
      @(negedge clk);
      wr_en = 1'b0;
      check("R9 x kept", 32'(x_ofs), 32'h0C3);
      check("R9 y kept", 32'(y_ofs), 32'h2A5);
   endtask

   task automatic t_serial;
      logic [2*AW-1:0] stream;
      stream = {10'h3C1, 10'h05A};
      do_reset(2'b11);
      for (int i = 2*AW-1; i >= 0; i--) begin
         cfg_sel_n = 1'b0; cfg_dat = stream[i];
         @(negedge clk);
         if (i % 7 == 3) begin
            cfg_sel_n = 1'b1; cfg_dat = ~cfg_dat;
            @(negedge clk);
            @(negedge clk);
         end
         if (i == 1) check("R8 not done before last bit", 32'(prog_done), 0);
      end
      cfg_sel_n = 1'b1;
      check("R8 done after 20 bits", 32'(prog_done), 1);
      check("R7 y", 32'(y_ofs), 32'h3C1);
      check("R7 x", 32'(x_ofs), 32'h05A);
      wr_en = 1'b1;
      #1 check("R6 serial write passes", 32'(fifo_wr_en), 1);
      @(negedge clk);
      wr_en = 1'b0;
      for (int k = 0; k < 4; k++) begin
         cfg_sel_n = 1'b0; cfg_dat = k[0];
         @(negedge clk);
      end
      cfg_sel_n = 1'b1;
      check("R8 extra bits ignored x", 32'(x_ofs), 32'h05A);
      check("R8 extra bits ignored y", 32'(y_ofs), 32'h3C1);
      check("R9 done held", 32'(prog_done), 1);
   endtask

   initial begin
      fork
         begin
            t_reset;
            t_preset(1'b0);
            t_preset(1'b1);
            t_parallel;
            t_serial;
         end
         begin
            repeat (20000) @(posedge clk);
            errs++; checks++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule